// File: doc/BRIEF.md
# Redundant Voting Bit Synchronizer

This block carries one asynchronous control bit into a destination clock domain. It does not use a single flip-flop chain. Instead, the bit enters several identical synchronizer chains in parallel, and each chain is a short cascade of flip-flops on the destination clock. A final register combines the chain outputs.

With three chains, the combiner takes the 2-of-3 majority. A chain that settled late or to the wrong side is then outvoted. With two chains, the combiner loads a new value only when both chains report the same level. While they disagree, it keeps its last value.

Chain depth (two or three stages) and chain count (two or three) are parameters. The defaults are two stages and three chains. The block is meant for level signals such as enables and flags. Bus crossings and handshakes need other structures.

Top module: `redundant_bit_sync`

## Requirements
- R1: Each chain has STAGES flip-flops in series on the destination clock, and its first flip-flop samples the asynchronous input. With the defaults (STAGES=2, CHAINS=3), a level present on the input at a clock edge appears on the output STAGES+1 = 3 rising edges later.
- R2: With STAGES=3 the chains are one stage longer, and the input-to-output latency becomes 4 rising edges.
- R3: With three chains, the output register loads the 2-of-3 majority of the chain outputs (bit i = chain i). The value is 1 exactly when at least two chain bits are 1.
- R4: With two chains, when both chain outputs are equal, the output register loads that common value on the next rising edge.
- R5: With two chains, when the chain outputs differ, the output register keeps its previous value.
- R6: Reset is synchronous and active low. A rising edge with the reset low clears every chain stage and the output register to 0, whatever the input level. After release, a 1 on the input needs the full latency to reach the output.
- R7: The output is registered. It changes only at a rising edge of the destination clock, never combinationally from the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination clock |
| rst_n | input | 1 | Synchronous reset, active low |
| async_bit | input | 1 | Asynchronous input level |
| sync_bit | output | 1 | Synchronized, voted output level |

## Verification
Two events can fall on the same destination edge: a reset and a pending input level in the chains. The bench holds the input at 1 until the output is 1, then lowers the reset while keeping the input high. It requires the output and every voter to read 0 one edge later, and it requires the 1 to reappear only after the full latency once reset releases.

The vote and the hold-on-disagreement path cannot be forced through the top, because identical chains always agree in simulation. The bench therefore drives the combiner directly with all eight three-bit patterns. It also drives an agree/disagree sequence for two chains and judges each result one edge after the pattern is applied.

// File: rtl/rsync_pkg.sv
// Package: rsync_pkg
// Shared defaults and the combining function for the redundant synchronizer.
// Assumes chain depth and chain count are each either 2 or 3.
package rsync_pkg;

    localparam int unsigned DEF_STAGES = 2;
    localparam int unsigned DEF_CHAINS = 3;

    // Two-of-three majority of three chain outputs.
    function automatic logic majority3(input logic [2:0] b);
        return (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]);
    endfunction

endpackage

// File: rtl/sync_chain.sv
// Module: sync_chain
// One synchronizer chain: STAGES flip-flops in series on the destination clock.
// The first stage samples the asynchronous input directly.
// Assumes STAGES >= 2 and a synchronous active-low reset.
module sync_chain #(
    parameter int unsigned STAGES = rsync_pkg::DEF_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] stg;

    // Shift the input level through the chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], d_async};
        end
    end

    assign q_sync = stg[STAGES-1];

    // R1: first stage takes the input level seen at the previous edge.
    a_r1_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg[0] == $past(d_async));

    // R1: each later stage takes the value its predecessor held one edge earlier.
    for (genvar k = 1; k < STAGES; k++) begin : g_stage_chk
        a_r1_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> stg[k] == $past(stg[k-1]));
    end

endmodule

// File: rtl/bit_vote.sv
// Module: bit_vote
// Registered combiner of parallel chain outputs.
// CHAINS=3: loads the 2-of-3 majority. CHAINS=2: loads the common value when
// both chains agree, otherwise holds. Assumes CHAINS is 2 or 3.
module bit_vote #(
    parameter int unsigned CHAINS = rsync_pkg::DEF_CHAINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAINS-1:0] chain_bits,
    output logic              voted
);

    if (CHAINS == 3) begin : g_major
        // Register the majority of three chains.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                voted <= 1'b0;
            end else begin
                voted <= rsync_pkg::majority3(chain_bits[2:0]);
            end
        end

        // R3: output equals "at least two ones" of the previous chain bits.
        a_r3_majority: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> voted == ($past($countones(chain_bits)) >= 2));
    end else begin : g_agree
        logic same;
        assign same = (chain_bits[0] == chain_bits[1]);

        // Load the common value only when both chains agree.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                voted <= 1'b0;
            end else if (same) begin
                voted <= chain_bits[0];
            end
        end

        // R4: agreement loads the shared level.
        a_r4_agree_load: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && ($past(chain_bits) == 2'b00 || $past(chain_bits) == 2'b11)
            |-> voted == $past(chain_bits[1]));

        // R5: disagreement leaves the output unchanged.
        a_r5_disagree_hold: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && ($past(chain_bits) == 2'b01 || $past(chain_bits) == 2'b10)
            |-> $stable(voted));
    end

endmodule

// File: rtl/redundant_bit_sync.sv
// Module: redundant_bit_sync
// Brings one asynchronous bit into the clk domain through CHAINS parallel
// synchronizer chains of STAGES flip-flops each, then votes (3 chains) or
// agreement-gates (2 chains) the result into an output register.
// Assumes async_bit is a level held long enough for the destination to see it.
module redundant_bit_sync #(
    parameter int unsigned STAGES = rsync_pkg::DEF_STAGES,
    parameter int unsigned CHAINS = rsync_pkg::DEF_CHAINS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_bit,
    output logic sync_bit
);

    logic [CHAINS-1:0] chain_q;

    // Independent chains, all sampling the same asynchronous input.
    for (genvar c = 0; c < CHAINS; c++) begin : g_chain
        sync_chain #(.STAGES(STAGES)) chain_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (async_bit),
            .q_sync  (chain_q[c])
        );
    end

    // Registered combination of the chain outputs.
    bit_vote #(.CHAINS(CHAINS)) vote_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_bits (chain_q),
        .voted      (sync_bit)
    );

    // R7: when all chains agreed at the last edge, the output now holds that level.
    a_r7_unanimous: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(&chain_q) || $past(~|chain_q))
        |-> sync_bit == $past(chain_q[0]));

endmodule

// File: tb/redundant_bit_sync_tb_top.sv
`timescale 1ns/1ps
module redundant_bit_sync_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       q_a, q_b;
    logic [2:0] v3 = 3'b000;
    logic [1:0] v2 = 2'b00;
    logic       v3_q, v2_q;

    int checks = 0;
    int failures = 0;
    logic exp_a[$];
    logic exp_b[$];

    always #2.5 clk = ~clk;

    redundant_bit_sync dut_i (
        .clk(clk), .rst_n(rst_n), .async_bit(din), .sync_bit(q_a));

    redundant_bit_sync #(.STAGES(3), .CHAINS(2)) dut2_i (
        .clk(clk), .rst_n(rst_n), .async_bit(din), .sync_bit(q_b));

    bit_vote #(.CHAINS(3)) vote3_i (
        .clk(clk), .rst_n(rst_n), .chain_bits(v3), .voted(v3_q));

    bit_vote #(.CHAINS(2)) vote2_i (
        .clk(clk), .rst_n(rst_n), .chain_bits(v2), .voted(v2_q));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: apply a level and push what each design must show later.
    task automatic drive(input logic v);
        din = v;
        exp_a.push_back(v);
        exp_b.push_back(v);
    endtask

    // Monitor: pop and compare once each pipeline is full.
    task automatic monitor();
        if (exp_a.size() == 3) check("R1 latency 3", q_a, exp_a.pop_front());
        if (exp_b.size() == 4) check("R2 latency 4", q_b, exp_b.pop_front());
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        logic pat [16];
        logic v2_pat [7][2];
        logic v2_exp [7];
        string v2_req [7];

        pat = '{1,0,1,1,0,0,0,1,1,1,1,0,1,0,0,1};
        v2_pat = '{'{1,1},'{0,1},'{1,0},'{0,0},'{1,0},'{0,1},'{1,1}};
        v2_exp = '{1,1,1,0,0,0,1};
        v2_req = '{"R4","R5","R5","R4","R5","R5","R4"};

        // Reset phase.
        repeat (4) @(negedge clk);
        check("R6 reset out default", q_a, 1'b0);
        check("R6 reset out 3-stage", q_b, 1'b0);
        check("R6 reset voter3", v3_q, 1'b0);
        check("R6 reset voter2", v2_q, 1'b0);
        rst_n = 1'b1;

        // Scoreboard phase: chains hold zeros after reset.
        for (int i = 0; i < 3; i++) exp_a.push_back(1'b0);
        for (int i = 0; i < 4; i++) exp_b.push_back(1'b0);
        for (int i = 0; i < 16; i++) begin
            monitor();
            drive(pat[i]);
            @(negedge clk);
        end
        lfsr = 8'h5A;
        for (int i = 0; i < 48; i++) begin
            monitor();
            drive(lfsr[0]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            @(negedge clk);
        end
        for (int i = 0; i < 6; i++) begin
            monitor();
            drive(1'b1);
            @(negedge clk);
        end
        monitor();

        // Voter phase: all three-chain patterns (R3).
        for (int p = 0; p < 8; p++) begin
            v3 = p[2:0];
            @(negedge clk);
            check("R3 majority", v3_q, ((p & 1) + ((p >> 1) & 1) + ((p >> 2) & 1)) >= 2);
        end

        // Two-chain agreement and hold sequence (R4, R5).
        for (int s = 0; s < 7; s++) begin
            v2 = {v2_pat[s][0], v2_pat[s][1]};
            @(negedge clk);
            check(v2_req[s], v2_q, v2_exp[s]);
        end

        // Reset landing with a high input in flight (R6).
        v3 = 3'b111;
        v2 = 2'b11;
        din = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 steady high", q_a, 1'b1);
        check("R2 steady high", q_b, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 reset clears out", q_a, 1'b0);
        check("R6 reset clears 3-stage", q_b, 1'b0);
        check("R6 reset clears voter3", v3_q, 1'b0);
        check("R6 reset clears voter2", v2_q, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 chains cleared e1", q_a, 1'b0);
        @(negedge clk);
        check("R7 no early output e2", q_a, 1'b0);
        @(negedge clk);
        check("R6 full latency after release", q_a, 1'b1);
        check("R2 still pending", q_b, 1'b0);
        @(negedge clk);
        check("R2 full latency after release", q_b, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule